// File: doc/BRIEF.md
# Vector Quadword Load/Store Unit

This block executes the memory half of a vector coprocessor's load and store instructions against a small local data RAM that it holds itself. Each request carries an integer base register value, a signed 11-bit displacement, a 4-bit lane mask, an operation code, the current contents of the destination or source vector register, and an integer register value for word stores. From these it forms a byte address in a 16 KiB space that counts in 16-byte quadwords and wraps at the top. It then reads or writes 32-bit lanes of the addressed quadword.

Quadword loads return the addressed quadword merged into the supplied vector register under the lane mask. Integer word loads return the low 16 bits of one lane, chosen from the mask by fixed priority. Post-increment variants ignore the displacement and report the incremented base register for the caller to write back. Only the lower part of the address space, set by a parameter, holds RAM. Loads elsewhere return a fill pattern, and stores elsewhere are dropped. A separate flag reports requests whose address, before wrapping, lies outside the RAM window.

Top module: `vqls_unit`

## Requirements
- R1: The byte address is ((base + sign-extended offset) × 16 + lane byte offset), truncated to its low 14 bits. Bits 13:4 give the quadword index. The lane byte offset is zero for quadword operations.
- R2: Mask bit k selects lane 3−k, and lane i sits at bits [32i+31:32i]. A quadword load returns the memory value in selected lanes and the supplied `req_vreg` lane elsewhere. A quadword store writes only the selected lanes.
- R3: Operation codes: 0 quadword load, 1 quadword store, 2 post-increment quadword load, 3 post-increment quadword store, 4 integer word load, 5 integer word store. Every accepted load (0, 2, 4) gives exactly one `ld_valid` pulse in the cycle after the request. No other request gives one.
- R4: A quadword index at or above `WIN_QWORDS` is outside RAM. Loads there return 0xCCCCCCCC in every selected lane, and stores there change no RAM location.
- R5: Post-increment operations use a zero offset. In the request cycle they raise `base_upd_valid` with `base_upd_data` = base + 1 modulo 2^16.
- R6: Integer word operations pick the lane from the lowest set mask bit, which gives this byte offset: bit 0 → 0xC (lane 3), bit 1 → 0x8 (lane 2), bit 2 → 0x4 (lane 1), bit 3 → 0x0 (lane 0). A zero mask gives offset 0. A word load returns the low 16 bits of that lane in `ld_iword`.
- R7: An integer word store writes the 16-bit `req_ireg` zero-extended to 32 bits into the one chosen lane only.
- R8: In the request cycle, `range_flag` is high exactly when a defined operation's unwrapped byte address is ≥ `WIN_QWORDS`×16. The unwrapped address is read as a 32-bit unsigned value, so a negative sum counts as out of range.
- R9: A store takes effect at its request clock edge, so a load in the next cycle reads the new data.
- R10: After reset, and in any cycle without `ld_valid`, `ld_vdata` and `ld_iword` are zero. During quadword loads `ld_iword` is zero. During word loads `ld_vdata` equals the supplied `req_vreg`.
- R11: Operation codes 6 and 7 write nothing, raise no `ld_valid`, `range_flag` or `base_upd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (R3) |
| req_base | input | 16 | Base integer register value |
| req_offset | input | 11 | Signed displacement in quadwords |
| req_mask | input | 4 | Lane mask |
| req_vreg | input | 128 | Vector register: merge source for loads, data for stores |
| req_ireg | input | 16 | Integer register value for word stores |
| ld_valid | output | 1 | Load result valid pulse |
| ld_vdata | output | 128 | Merged quadword load result |
| ld_iword | output | 16 | Integer word load result |
| base_upd_valid | output | 1 | Post-increment write-back request |
| base_upd_data | output | 16 | Incremented base value |
| range_flag | output | 1 | Unwrapped address outside the RAM window |

## Verification
The bench builds the unit with `WIN_QWORDS` = 256, so RAM fills only the lower 4 KiB of the 16 KiB space. This leaves quadwords 256 to 1023 as non-RAM addresses. The bench uses them to check the fill pattern, dropped stores, the 255/256 window edge, and stores to index 300 that would alias onto 44 if the index were truncated. The 14-bit wrap is reached in two ways: a base near the top plus a positive offset folds back into RAM, and a negative sum lands at the top quadword.

// File: rtl/vqls_pkg.sv
package vqls_pkg;

   typedef enum logic [2:0] {
      VQ_LDQ     = 3'd0,
      VQ_STQ     = 3'd1,
      VQ_LDQ_INC = 3'd2,
      VQ_STQ_INC = 3'd3,
      VQ_LDW     = 3'd4,
      VQ_STW     = 3'd5
   } vq_op_e;

   function automatic logic op_is_load(input logic [2:0] op);
      return (op == VQ_LDQ) || (op == VQ_LDQ_INC) || (op == VQ_LDW);
   endfunction

   function automatic logic op_is_store(input logic [2:0] op);
      return (op == VQ_STQ) || (op == VQ_STQ_INC) || (op == VQ_STW);
   endfunction

   function automatic logic op_is_word(input logic [2:0] op);
      return (op == VQ_LDW) || (op == VQ_STW);
   endfunction

   function automatic logic op_is_postinc(input logic [2:0] op);
      return (op == VQ_LDQ_INC) || (op == VQ_STQ_INC);
   endfunction

endpackage

// File: rtl/vqls_addr_gen.sv
module vqls_addr_gen
   import vqls_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int LANE_W     = 32,
   parameter int IREG_W     = 16,
   parameter int OFFS_W     = 11,
   parameter int ADDR_W     = 14,
   parameter int WIN_QWORDS = 512
) (
   input  logic [2:0]                      op,
   input  logic [IREG_W-1:0]               base,
   input  logic [OFFS_W-1:0]               offset,
   input  logic [LANES-1:0]                mask,
   output logic [$clog2(WIN_QWORDS)-1:0]   ram_idx,
   output logic [$clog2(LANES)-1:0]        word_lane,
   output logic                            in_win,
   output logic                            range_hit
);

   localparam int     UA_W      = 32;
   localparam int     BYTE_SH   = $clog2(LANE_W / 8);
   localparam int     QW_SH     = $clog2(LANES * LANE_W / 8);
   localparam int     IDX_W     = ADDR_W - QW_SH;
   localparam int     LANE_AW   = $clog2(LANES);
   localparam int     MA_W      = $clog2(WIN_QWORDS);
   localparam longint WIN_BYTES = longint'(WIN_QWORDS) << QW_SH;

   logic [LANE_AW-1:0] pick;
   logic [UA_W-1:0]    base_ext;
   logic [UA_W-1:0]    off_ext;
   logic [UA_W-1:0]    lane_bytes;
   logic [UA_W-1:0]    sum;
   logic [UA_W-1:0]    ua;
   logic [IDX_W-1:0]   qidx;

   // lowest set mask bit wins: scan from the top so bit 0 is assigned last
   always_comb begin
      pick = '0;
      for (int k = LANES - 1; k >= 0; k--) begin
         if (mask[k]) pick = LANE_AW'(LANES - 1 - k);
      end
   end

   assign base_ext   = {{(UA_W - IREG_W){1'b0}}, base};
   assign off_ext    = {{(UA_W - OFFS_W){offset[OFFS_W-1]}}, offset};
   assign lane_bytes = op_is_word(op) ? UA_W'({pick, {BYTE_SH{1'b0}}}) : '0;
   assign sum        = base_ext + (op_is_postinc(op) ? '0 : off_ext);
   assign ua         = (sum << QW_SH) + lane_bytes;
   assign qidx       = ua[ADDR_W-1:QW_SH];
   assign word_lane  = ua[QW_SH-1:BYTE_SH];
   assign range_hit  = (ua >= UA_W'(WIN_BYTES));

   generate
      if (WIN_QWORDS == (1 << IDX_W)) begin : g_full_win
         assign ram_idx = qidx;
         assign in_win  = 1'b1;
      end else begin : g_part_win
         assign ram_idx = qidx[MA_W-1:0];
         assign in_win  = (qidx < IDX_W'(WIN_QWORDS));
      end
   endgenerate

endmodule

// File: rtl/vqls_lane_ram.sv
module vqls_lane_ram #(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   parameter int DEPTH  = 512
) (
   input  logic                       clk,
   input  logic [LANES-1:0]           we,
   input  logic                       re,
   input  logic [$clog2(DEPTH)-1:0]   idx,
   input  logic [LANES*LANE_W-1:0]    wdata,
   output logic [LANES*LANE_W-1:0]    rdata
);

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];
         logic [LANE_W-1:0] rd_q;

         always_ff @(posedge clk) begin
            if (we[l]) mem[idx] <= wdata[l*LANE_W +: LANE_W];
            if (re)    rd_q     <= mem[idx];
         end

         assign rdata[l*LANE_W +: LANE_W] = rd_q;
      end
   endgenerate

endmodule

// File: rtl/vqls_load_merge.sv
module vqls_load_merge #(
   parameter int                LANES     = 4,
   parameter int                LANE_W    = 32,
   parameter int                IREG_W    = 16,
   parameter logic [LANE_W-1:0] FILL_WORD = {(LANE_W / 8){8'hCC}}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cap,
   input  logic                       is_word,
   input  logic                       in_win,
   input  logic [LANES-1:0]           sel,
   input  logic [$clog2(LANES)-1:0]   word_lane,
   input  logic [LANES*LANE_W-1:0]    vreg,
   input  logic [LANES*LANE_W-1:0]    rdata,
   output logic                       ld_valid,
   output logic [LANES*LANE_W-1:0]    ld_vdata,
   output logic [IREG_W-1:0]          ld_iword
);

   localparam int LANE_AW = $clog2(LANES);
   localparam int VEC_W   = LANES * LANE_W;

   logic               valid_q;
   logic               word_q;
   logic               hit_q;
   logic [LANES-1:0]   sel_q;
   logic [LANE_AW-1:0] lane_q;
   logic [VEC_W-1:0]   vreg_q;
   logic [VEC_W-1:0]   src;
   logic [IREG_W-1:0]  iw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         word_q  <= 1'b0;
         hit_q   <= 1'b0;
         sel_q   <= '0;
         lane_q  <= '0;
         vreg_q  <= '0;
      end else begin
         valid_q <= cap;
         if (cap) begin
            word_q <= is_word;
            hit_q  <= in_win;
            sel_q  <= sel;
            lane_q <= word_lane;
            vreg_q <= vreg;
         end
      end
   end

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_src
         assign src[l*LANE_W +: LANE_W] = hit_q ? rdata[l*LANE_W +: LANE_W] : FILL_WORD;
         assign ld_vdata[l*LANE_W +: LANE_W] =
            !valid_q             ? '0 :
            (!word_q && sel_q[l]) ? src[l*LANE_W +: LANE_W] :
                                   vreg_q[l*LANE_W +: LANE_W];
      end
   endgenerate

   always_comb begin
      iw = '0;
      for (int k = 0; k < LANES; k++) begin
         if (lane_q == LANE_AW'(k)) iw = src[k*LANE_W +: IREG_W];
      end
   end

   assign ld_valid = valid_q;
   assign ld_iword = (valid_q && word_q) ? iw : '0;

endmodule

// File: rtl/vqls_unit.sv
module vqls_unit
   import vqls_pkg::*;
#(
   parameter int                LANES      = 4,
   parameter int                LANE_W     = 32,
   parameter int                IREG_W     = 16,
   parameter int                OFFS_W     = 11,
   parameter int                ADDR_W     = 14,
   parameter int                WIN_QWORDS = 512,
   parameter logic [LANE_W-1:0] FILL_WORD  = {(LANE_W / 8){8'hCC}}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [2:0]                 req_op,
   input  logic [IREG_W-1:0]          req_base,
   input  logic [OFFS_W-1:0]          req_offset,
   input  logic [LANES-1:0]           req_mask,
   input  logic [LANES*LANE_W-1:0]    req_vreg,
   input  logic [IREG_W-1:0]          req_ireg,
   output logic                       ld_valid,
   output logic [LANES*LANE_W-1:0]    ld_vdata,
   output logic [IREG_W-1:0]          ld_iword,
   output logic                       base_upd_valid,
   output logic [IREG_W-1:0]          base_upd_data,
   output logic                       range_flag
);

   localparam int VEC_W   = LANES * LANE_W;
   localparam int QW_SH   = $clog2(VEC_W / 8);
   localparam int IDX_W   = ADDR_W - QW_SH;
   localparam int LANE_AW = $clog2(LANES);
   localparam int MA_W    = $clog2(WIN_QWORDS);

   generate
      if (WIN_QWORDS < 2 || WIN_QWORDS > (1 << IDX_W)) begin : g_bad_win
         $error("vqls_unit: WIN_QWORDS must lie in 2..2**(ADDR_W-QW_SH)");
      end
      if (LANE_W < IREG_W || (LANE_W % 8) != 0) begin : g_bad_lane
         $error("vqls_unit: LANE_W must be whole bytes and hold IREG_W");
      end
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("vqls_unit: LANES must be a power of two of at least 2");
      end
   endgenerate

   logic [MA_W-1:0]    ram_idx;
   logic [LANE_AW-1:0] word_lane;
   logic               in_win;
   logic               range_hit;
   logic               is_load;
   logic               is_store;
   logic               is_word;
   logic [LANES-1:0]   quad_sel;
   logic [LANES-1:0]   word_sel;
   logic [LANES-1:0]   sel;
   logic [LANES-1:0]   we;
   logic [VEC_W-1:0]   wdata;
   logic [VEC_W-1:0]   word_rep;
   logic [VEC_W-1:0]   rdata;

   vqls_addr_gen #(
      .LANES      (LANES),
      .LANE_W     (LANE_W),
      .IREG_W     (IREG_W),
      .OFFS_W     (OFFS_W),
      .ADDR_W     (ADDR_W),
      .WIN_QWORDS (WIN_QWORDS)
   ) i_addr (
      .op        (req_op),
      .base      (req_base),
      .offset    (req_offset),
      .mask      (req_mask),
      .ram_idx   (ram_idx),
      .word_lane (word_lane),
      .in_win    (in_win),
      .range_hit (range_hit)
   );

   assign is_load  = op_is_load(req_op);
   assign is_store = op_is_store(req_op);
   assign is_word  = op_is_word(req_op);

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_sel
         assign quad_sel[l] = req_mask[LANES-1-l];
         assign word_sel[l] = (word_lane == LANE_AW'(l));
         if (LANE_W == IREG_W) begin : g_nopad
            assign word_rep[l*LANE_W +: LANE_W] = req_ireg;
         end else begin : g_pad
            assign word_rep[l*LANE_W +: LANE_W] = {{(LANE_W - IREG_W){1'b0}}, req_ireg};
         end
      end
   endgenerate

   assign sel   = is_word ? word_sel : quad_sel;
   assign we    = (req_valid && is_store && in_win) ? sel : '0;
   assign wdata = is_word ? word_rep : req_vreg;

   vqls_lane_ram #(
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .DEPTH  (WIN_QWORDS)
   ) i_ram (
      .clk   (clk),
      .we    (we),
      .re    (req_valid && is_load),
      .idx   (ram_idx),
      .wdata (wdata),
      .rdata (rdata)
   );

   vqls_load_merge #(
      .LANES     (LANES),
      .LANE_W    (LANE_W),
      .IREG_W    (IREG_W),
      .FILL_WORD (FILL_WORD)
   ) i_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (req_valid && is_load),
      .is_word   (is_word),
      .in_win    (in_win),
      .sel       (sel),
      .word_lane (word_lane),
      .vreg      (req_vreg),
      .rdata     (rdata),
      .ld_valid  (ld_valid),
      .ld_vdata  (ld_vdata),
      .ld_iword  (ld_iword)
   );

   assign base_upd_valid = req_valid && op_is_postinc(req_op);
   assign base_upd_data  = req_base + IREG_W'(1);
   assign range_flag     = req_valid && (is_load || is_store) && range_hit;

endmodule

// File: rtl/vqls_unit_chk.sv
module vqls_unit_chk #(
   parameter int LANES      = 4,
   parameter int LANE_W     = 32,
   parameter int IREG_W     = 16,
   parameter int OFFS_W     = 11,
   parameter int WIN_QWORDS = 512
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic [2:0]               req_op,
   input logic [IREG_W-1:0]        req_base,
   input logic [OFFS_W-1:0]        req_offset,
   input logic [LANES-1:0]         req_mask,
   input logic [LANES*LANE_W-1:0]  req_vreg,
   input logic                     ld_valid,
   input logic [LANES*LANE_W-1:0]  ld_vdata,
   input logic [IREG_W-1:0]        ld_iword,
   input logic                     base_upd_valid,
   input logic [IREG_W-1:0]        base_upd_data,
   input logic                     range_flag
);

   // R3
   load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 3'd0 || req_op == 3'd2 || req_op == 3'd4)) |=> ld_valid);

   // R3
   no_spurious_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && (req_op == 3'd0 || req_op == 3'd2 || req_op == 3'd4)) |=> !ld_valid);

   // R2
   empty_mask_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd0 && req_mask == '0) |=> (ld_vdata == $past(req_vreg)));

   // R10
   quad_iword_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 3'd0 || req_op == 3'd2)) |=> (ld_iword == '0));

   // R5
   postinc_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_upd_valid |-> (base_upd_data != req_base));

   // R8
   high_base_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op <= 3'd5 && !req_offset[OFFS_W-1] && (32'(req_base) >= 32'(WIN_QWORDS)))
      |-> range_flag);

   // R11
   undef_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op >= 3'd6) |-> (!range_flag && !base_upd_valid));

endmodule

bind vqls_unit vqls_unit_chk #(
   .LANES      (LANES),
   .LANE_W     (LANE_W),
   .IREG_W     (IREG_W),
   .OFFS_W     (OFFS_W),
   .WIN_QWORDS (WIN_QWORDS)
) i_vqls_unit_chk (.*);

// File: tb/test_vqls_unit.sv
module test_vqls_unit;

   localparam int WIN   = 256;
   localparam int VEC_W = 128;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic [2:0]         req_op = '0;
   logic [15:0]        req_base = '0;
   logic [10:0]        req_offset = '0;
   logic [3:0]         req_mask = '0;
   logic [VEC_W-1:0]   req_vreg = '0;
   logic [15:0]        req_ireg = '0;
   logic               ld_valid;
   logic [VEC_W-1:0]   ld_vdata;
   logic [15:0]        ld_iword;
   logic               base_upd_valid;
   logic [15:0]        base_upd_data;
   logic               range_flag;

   always #5 clk = ~clk;

   vqls_unit #(.WIN_QWORDS(WIN)) i_vqls_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_base(req_base), .req_offset(req_offset), .req_mask(req_mask),
      .req_vreg(req_vreg), .req_ireg(req_ireg), .ld_valid(ld_valid),
      .ld_vdata(ld_vdata), .ld_iword(ld_iword), .base_upd_valid(base_upd_valid),
      .base_upd_data(base_upd_data), .range_flag(range_flag)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [VEC_W-1:0] model [0:1023];

   typedef struct {
      logic [VEC_W-1:0] v;
      logic [15:0]      w;
      string            req;
   } exp_t;
   exp_t expq[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int lane_pick(input logic [3:0] m);
      if (m[0]) return 3;
      if (m[1]) return 2;
      if (m[2]) return 1;
      return 0;
   endfunction

   // drive one request for one cycle; check request-cycle outputs; update the model
   task automatic issue(input logic [2:0] op, input logic [15:0] base, input logic [10:0] off,
                        input logic [3:0] m, input logic [VEC_W-1:0] vreg,
                        input logic [15:0] ireg, input string req);
      bit               post, word, known;
      int               s, ln, qi;
      logic [31:0]      ua;
      bit               inwin;
      logic [VEC_W-1:0] v;
      logic [31:0]      src;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_base = base; req_offset = off;
      req_mask = m; req_vreg = vreg; req_ireg = ireg;
      #1;
      post  = (op == 3'd2) || (op == 3'd3);
      word  = (op == 3'd4) || (op == 3'd5);
      known = (op <= 3'd5);
      ln    = word ? lane_pick(m) : 0;
      s     = int'(base) + (post ? 0 : int'($signed(off)));
      ua    = 32'(s * 16 + ln * 4);
      qi    = int'(ua[13:4]);
      inwin = (qi < WIN);
      chk(range_flag == (known && (ua >= 32'(WIN * 16))), {req, " R8"}, "range_flag",
          VEC_W'(range_flag), VEC_W'(known && (ua >= 32'(WIN * 16))));
      chk(base_upd_valid == post, {req, " R5"}, "base_upd_valid",
          VEC_W'(base_upd_valid), VEC_W'(post));
      if (post)
         chk(base_upd_data == base + 16'd1, {req, " R5"}, "base_upd_data",
             VEC_W'(base_upd_data), VEC_W'(base + 16'd1));
      case (op)
         3'd0, 3'd2: begin
            for (int i = 0; i < 4; i++) begin
               src = inwin ? model[qi][32*i +: 32] : 32'hCCCC_CCCC;
               v[32*i +: 32] = m[3-i] ? src : vreg[32*i +: 32];
            end
            expq.push_back('{v, 16'h0, req});
         end
         3'd4: begin
            src = inwin ? model[qi][32*ln +: 32] : 32'hCCCC_CCCC;
            expq.push_back('{vreg, src[15:0], req});
         end
         3'd1, 3'd3: begin
            if (inwin)
               for (int i = 0; i < 4; i++)
                  if (m[3-i]) model[qi][32*i +: 32] = vreg[32*i +: 32];
         end
         3'd5: begin
            if (inwin) model[qi][32*ln +: 32] = {16'h0, ireg};
         end
         default: ;
      endcase
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && ld_valid) begin
         if (expq.size() == 0) begin
            chk(0, "R3", "unexpected ld_valid", VEC_W'(1), VEC_W'(0));
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk(ld_vdata == e.v, {e.req, " R2"}, "ld_vdata", ld_vdata, e.v);
            chk(ld_iword == e.w, {e.req, " R6"}, "ld_iword", VEC_W'(ld_iword), VEC_W'(e.w));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   localparam logic [VEC_W-1:0] D1 = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
   localparam logic [VEC_W-1:0] D2 = 128'hAAAA_0004_AAAA_0003_AAAA_0002_AAAA_0001;
   localparam logic [VEC_W-1:0] D3 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
   localparam logic [VEC_W-1:0] D4 = 128'hDEAD_0004_DEAD_0003_DEAD_0002_DEAD_0001;
   localparam logic [VEC_W-1:0] D5 = 128'h5555_5555_6666_6666_7777_7777_8888_8888;
   localparam logic [VEC_W-1:0] D6 = 128'hFFFF_FFFF_EEEE_EEEE_DDDD_DDDD_BBBB_BBBB;
   localparam logic [VEC_W-1:0] VX = 128'h9999_0003_9999_0002_9999_0001_9999_0000;

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(ld_valid == 1'b0, "R10", "reset ld_valid", VEC_W'(ld_valid), '0);
      chk(ld_vdata == '0, "R10", "reset ld_vdata", ld_vdata, '0);
      chk(ld_iword == '0, "R10", "reset ld_iword", VEC_W'(ld_iword), '0);
      chk(range_flag == 1'b0 && base_upd_valid == 1'b0, "R10", "reset flags",
          VEC_W'({range_flag, base_upd_valid}), '0);
      rst_n = 1'b1;
      idle(2);

      // R1 R3 R9: full store then back-to-back load
      issue(3'd1, 16'd5, 11'd0, 4'hF, D1, 16'h0, "R1 full store");
      issue(3'd0, 16'd5, 11'd0, 4'hF, VX, 16'h0, "R9 load after store");
      // R2: partial store (bits 0,2 -> lanes 3,1) and partial load merge
      issue(3'd1, 16'd5, 11'd0, 4'b0101, D2, 16'h0, "R2 partial store");
      issue(3'd0, 16'd5, 11'd0, 4'hF, VX, 16'h0, "R2 merged read");
      issue(3'd0, 16'd5, 11'd0, 4'b1000, VX, 16'h0, "R2 lane0 merge");
      issue(3'd0, 16'd5, 11'd0, 4'b0000, VX, 16'h0, "R2 empty mask");
      // R1: negative offset (10 - 3 = 7)
      issue(3'd1, 16'd10, 11'h7FD, 4'hF, D3, 16'h0, "R1 neg offset store");
      issue(3'd0, 16'd7, 11'd0, 4'hF, VX, 16'h0, "R1 neg offset load");
      // R1 R8: wrap 1023+2 -> quadword 1, flagged
      issue(3'd1, 16'd1023, 11'd2, 4'hF, D4, 16'h0, "R1 wrap store");
      issue(3'd0, 16'd1, 11'd0, 4'hF, VX, 16'h0, "R1 wrap load");
      // R4: dropped store to 300 must not alias onto 44
      issue(3'd1, 16'd44, 11'd0, 4'hF, D5, 16'h0, "R4 store 44");
      issue(3'd1, 16'd300, 11'd0, 4'hF, D6, 16'h0, "R4 store outside");
      issue(3'd0, 16'd44, 11'd0, 4'hF, VX, 16'h0, "R4 no alias");
      issue(3'd0, 16'd300, 11'd0, 4'b0110, VX, 16'h0, "R4 fill lanes");
      // R4 R8: window edge
      issue(3'd1, 16'd255, 11'd0, 4'hF, D6, 16'h0, "R8 last in window");
      issue(3'd0, 16'd255, 11'd0, 4'hF, VX, 16'h0, "R8 load last");
      issue(3'd0, 16'd256, 11'd0, 4'hF, VX, 16'h0, "R4 first outside");
      // R1 R8: negative sum -> top quadword
      issue(3'd0, 16'd0, 11'h7FF, 4'hF, VX, 16'h0, "R1 negative sum");
      // R5: post-increment ignores offset
      issue(3'd3, 16'd20, 11'd5, 4'hF, D3, 16'h0, "R5 store inc");
      issue(3'd2, 16'd20, 11'd7, 4'hF, VX, 16'h0, "R5 load inc");
      issue(3'd2, 16'hFFFF, 11'd0, 4'hF, VX, 16'h0, "R5 inc wrap");
      // R7: word store into chosen lane only
      issue(3'd1, 16'd30, 11'd0, 4'hF, D1, 16'h0, "R7 prefill");
      issue(3'd5, 16'd30, 11'd0, 4'b0011, VX, 16'hBEEF, "R7 word store lane3");
      issue(3'd5, 16'd28, 11'd2, 4'b0000, VX, 16'h1234, "R7 word store lane0");
      issue(3'd0, 16'd30, 11'd0, 4'hF, VX, 16'h0, "R7 readback");
      // R6: priority of word lane selection
      issue(3'd4, 16'd30, 11'd0, 4'b1111, VX, 16'h0, "R6 bit0 wins");
      issue(3'd4, 16'd30, 11'd0, 4'b1110, VX, 16'h0, "R6 bit1 wins");
      issue(3'd4, 16'd30, 11'd0, 4'b1100, VX, 16'h0, "R6 bit2 wins");
      issue(3'd4, 16'd30, 11'd0, 4'b1000, VX, 16'h0, "R6 bit3");
      issue(3'd4, 16'd5, 11'd0, 4'b0000, VX, 16'h0, "R6 zero mask");
      issue(3'd4, 16'd400, 11'd0, 4'b0001, VX, 16'h0, "R6 word outside");
      // R11: undefined codes do nothing
      issue(3'd6, 16'd30, 11'd0, 4'hF, D6, 16'h7777, "R11 code6");
      issue(3'd7, 16'd2000, 11'd0, 4'hF, D6, 16'h7777, "R11 code7");
      issue(3'd0, 16'd30, 11'd0, 4'hF, VX, 16'h0, "R11 memory intact");
      idle(4);
      chk(expq.size() == 0, "R3", "loads without ld_valid",
          VEC_W'(expq.size()), '0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule